// File: doc/BRIEF.md
# Rounding Lane Shift-and-Pack Unit

This block performs right shifts on a 32-bit operand treated either as packed lanes or as whole words. It has three operations. The first is a signed arithmetic shift applied to each of four byte lanes. The second is an unsigned logical shift applied to each of two halfword lanes. The third is a narrowing pack: two signed words are shifted by the same amount, and the low half of each lands in its own half of the result.

The byte shift and the pack can round. When rounding is enabled, the last bit shifted out of a lane is added back into that lane. All lane arithmetic is done by combinational logic. The result is captured in a single output register when a valid strobe is presented, which suits the block to one execute stage of a datapath.

Top module: `lane_shift_pack`

## Requirements
- R1: With op_i = 2'b00 each of the four bytes of opa_i is shifted right arithmetically by amt_i[2:0], and the vacated bits are filled with the lane's sign bit. amt_i[4:3] is ignored in this mode.
- R2: In byte mode and in pack mode, when round_i = 1 and the shift is nonzero, one is added to a lane's shifted value if bit (shift-1) of the original lane is 1.
- R3: A shift of zero returns every lane unchanged, whatever the value of round_i.
- R4: With op_i = 2'b01 each 16-bit half of opa_i is shifted right logically by amt_i[3:0] with zero fill. round_i and amt_i[4] have no effect in this mode.
- R5: With op_i = 2'b10, opa_i and opb_i are each shifted right arithmetically by amt_i[4:0], with the rounding of R2. The low 16 bits of the shifted opa_i go to result bits [31:16], and the low 16 bits of the shifted opb_i go to bits [15:0].
- R6: A rounding increment wraps within its own lane (8 bits in byte mode, 32 bits in pack mode), and no carry passes into a neighbouring lane.
- R7: op_i = 2'b11 is reserved and loads a result of zero.
- R8: result_o takes the new value on the first rising clock edge at which valid_i = 1 and holds it while valid_i = 0. An asynchronous reset (rst_ni low) clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load strobe for the result register |
| op_i | input | 2 | 00 byte shift, 01 halfword shift, 10 pack, 11 reserved |
| round_i | input | 1 | Rounding enable |
| amt_i | input | 5 | Shift amount; byte mode uses bits [2:0], halfword mode uses bits [3:0] |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (pack mode only) |
| result_o | output | 32 | Registered result |

## Verification
All of the lane logic sits in front of the single result register. Any fault in a lane, in the rounding-bit select or in the mode mux therefore shows up at result_o one clock after the valid strobe, and only in the lanes it affects. The directed vectors are chosen so that such faults are visible. A byte lane of 0xFF that rounds up would show a leaked carry as a nonzero neighbour byte. A wrong rounding-bit index shows up at the largest shift amounts. A wrong field width shows up when the unused upper bits of amt_i are set. Faults in the enable or the reset of the register appear as a result that changes while valid_i is low, or that is not zero while reset is applied.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  typedef enum logic [1:0] {
    OP_BYTE_SRA = 2'd0,
    OP_HALF_SRL = 2'd1,
    OP_PACK     = 2'd2,
    OP_RSVD     = 2'd3
  } lsp_op_e;
endpackage

// File: rtl/lsp_sra_lane.sv
// Signed right shift of one lane with optional round-half-up on the last bit out.
module lsp_sra_lane #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic [W-1:0]  lane_i,
  input  logic [AW-1:0] amt_i,
  input  logic          round_i,
  output logic [W-1:0]  lane_o
);
  logic signed [W-1:0] shifted;
  logic [AW-1:0]       last_idx;
  logic                inc;

  always_comb begin
    shifted  = $signed(lane_i) >>> amt_i;
    last_idx = amt_i - 1'b1;
    inc      = round_i && (amt_i != '0) && lane_i[last_idx];
    // increment wraps inside the lane
    lane_o   = shifted + {{(W-1){1'b0}}, inc};
  end
endmodule

// File: rtl/lsp_srl_lane.sv
module lsp_srl_lane #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic [W-1:0]  lane_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  lane_o
);
  always_comb lane_o = lane_i >> amt_i;
endmodule

// File: rtl/lane_shift_pack.sv
module lane_shift_pack
  import lsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  op_i,
  input  logic        round_i,
  input  logic [4:0]  amt_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  output logic [31:0] result_o
);
  localparam int NB  = DATA_W / BYTE_W;
  localparam int NH  = DATA_W / HALF_W;
  localparam int BAW = $clog2(BYTE_W);
  localparam int HAW = $clog2(HALF_W);
  localparam int WAW = $clog2(DATA_W);
  localparam int PW  = DATA_W / 2;

  lsp_op_e            op;
  logic [DATA_W-1:0]  byte_res, half_res, pack_res, next_res;
  logic [DATA_W-1:0]  word_res [2];
  logic [DATA_W-1:0]  word_src [2];

  assign op          = lsp_op_e'(op_i);
  assign word_src[0] = opa_i;
  assign word_src[1] = opb_i;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    lsp_sra_lane #(.W(BYTE_W), .AW(BAW)) i_lane (
      .lane_i  (opa_i[b*BYTE_W +: BYTE_W]),
      .amt_i   (amt_i[BAW-1:0]),
      .round_i (round_i),
      .lane_o  (byte_res[b*BYTE_W +: BYTE_W])
    );
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    lsp_srl_lane #(.W(HALF_W), .AW(HAW)) i_lane (
      .lane_i (opa_i[h*HALF_W +: HALF_W]),
      .amt_i  (amt_i[HAW-1:0]),
      .lane_o (half_res[h*HALF_W +: HALF_W])
    );
  end

  for (genvar w = 0; w < 2; w++) begin : g_word
    lsp_sra_lane #(.W(DATA_W), .AW(WAW)) i_lane (
      .lane_i  (word_src[w]),
      .amt_i   (amt_i[WAW-1:0]),
      .round_i (round_i),
      .lane_o  (word_res[w])
    );
  end

  // first operand to the upper half, second to the lower half
  assign pack_res = {word_res[0][PW-1:0], word_res[1][PW-1:0]};

  always_comb begin
    unique case (op)
      OP_BYTE_SRA: next_res = byte_res;
      OP_HALF_SRL: next_res = half_res;
      OP_PACK:     next_res = pack_res;
      default:     next_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      result_o <= '0;
    else if (valid_i) result_o <= next_res;
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  // R3
  byte_zero_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b00 && amt_i[BAW-1:0] == '0 |=> result_o == $past(opa_i));

  // R1
  byte_sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b00 && !round_i |=>
      result_o[DATA_W-1] == $past(opa_i[DATA_W-1]) && result_o[BYTE_W-1] == $past(opa_i[BYTE_W-1]));

  // R4
  half_zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b01 && amt_i[HAW-1:0] != '0 |=>
      !result_o[DATA_W-1] && !result_o[HALF_W-1]);

  // R5
  pack_zero_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b10 && amt_i == '0 |=>
      result_o == {$past(opa_i[PW-1:0]), $past(opb_i[PW-1:0])});

  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b11 |=> result_o == '0);
endmodule

// File: tb/test_lane_shift_pack.sv
module test_lane_shift_pack;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        round_i = 1'b0;
  logic [4:0]  amt_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] result_o;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  lane_shift_pack i_lane_shift_pack (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .round_i(round_i),
    .amt_i(amt_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o)
  );

  // {op, round, amt, a, b, expected}
  localparam int NV = 16;
  localparam logic [103:0] VEC [NV] = '{
    {2'b00, 1'b1, 5'd0,  32'h807F01FF, 32'h0,        32'h807F01FF},
    {2'b00, 1'b0, 5'd1,  32'h807F03FE, 32'h0,        32'hC03F01FF},
    {2'b00, 1'b1, 5'd1,  32'h807F03FE, 32'h0,        32'hC04002FF},
    {2'b00, 1'b1, 5'd7,  32'h7FC04081, 32'h0,        32'h010001FF},
    {2'b00, 1'b1, 5'd1,  32'h0000FFFF, 32'h0,        32'h00000000},
    {2'b00, 1'b0, 5'd27, 32'h40F01888, 32'h0,        32'h08FE03F1},
    {2'b01, 1'b1, 5'd4,  32'hFFFF8421, 32'h0,        32'h0FFF0842},
    {2'b01, 1'b0, 5'd15, 32'h80007FFF, 32'h0,        32'h00010000},
    {2'b01, 1'b1, 5'd0,  32'hABCD1234, 32'h0,        32'hABCD1234},
    {2'b01, 1'b0, 5'd17, 32'h00020003, 32'h0,        32'h00010001},
    {2'b10, 1'b1, 5'd0,  32'h12345678, 32'h9ABCDEF0, 32'h5678DEF0},
    {2'b10, 1'b0, 5'd16, 32'h12345678, 32'h9ABCDEF0, 32'h12349ABC},
    {2'b10, 1'b1, 5'd16, 32'h12345678, 32'h9ABCDEF0, 32'h12349ABD},
    {2'b10, 1'b1, 5'd31, 32'h80000000, 32'h40000000, 32'hFFFF0001},
    {2'b10, 1'b1, 5'd1,  32'hFFFFFFFF, 32'h00000003, 32'h00000002},
    {2'b11, 1'b1, 5'd3,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
  };
  localparam string TAG [NV] = '{
    "R3 byte zero shift", "R1 byte sra", "R2 byte round", "R6 byte round wrap amt7",
    "R6 byte no carry", "R1 byte amt field", "R4 half round ignored", "R4 half amt15",
    "R3 half zero shift", "R4 half amt field", "R5 pack zero shift", "R5 pack amt16",
    "R2 pack round", "R5 pack amt31", "R6 pack word wrap", "R7 reserved op"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [103:0] v);
    @(negedge clk);
    {op_i, round_i, amt_i, opa_i, opb_i} = v[103:32];
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 reset value", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", result_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk(TAG[i], result_o, VEC[i][31:0]);
    end

    // R8: inputs change with valid low, result holds
    apply({2'b00, 1'b0, 5'd1, 32'h807F03FE, 32'h0, 32'h0});
    chk("R8 load", result_o, 32'hC03F01FF);
    @(negedge clk);
    op_i = 2'b01; amt_i = 5'd0; opa_i = 32'h12345678;
    repeat (3) @(negedge clk);
    chk("R8 hold with valid low", result_o, 32'hC03F01FF);

    // R8: asynchronous reset mid-run
    @(negedge clk);
    #3 rst_ni = 1'b0;
    #2 chk("R8 async clear", result_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    apply({2'b10, 1'b0, 5'd0, 32'h0000AAAA, 32'h00005555, 32'h0});
    chk("R5 after reset", result_o, 32'hAAAA5555);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R8: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule